// File: doc/BRIEF.md
# Bus Master Priority Arbiter

This block decides which of four requesters owns the system bus: the memory refresh engine, DMA channel 0, DMA channel 1, or an external bus master. Refresh always wins when it asks. The other three always keep the same cyclic order (channel 0, then channel 1, then the external master), and a two-bit mode only chooses where that circle is cut. Three modes fix one requester at the bottom. The fourth mode rotates the order so that each winner drops to the lowest rank.

Ownership is sticky. A grant is kept for as long as the owner keeps its request high. When the owner lets go, a new winner is chosen, but only in a cycle where the bus is reported idle. The grant is registered, so a decision made from the inputs of one cycle appears on `grant` after the next rising clock edge.

Top module: `bus_grant_arbiter`

## Requirements
- R1: When arbitration takes place and `req_refresh` is high, the next grant is refresh (`grant` = 4'b0001), whatever the other requests and the mode are. Grant bits: bit0 refresh, bit1 DMA channel 0, bit2 DMA channel 1, bit3 external master.
- R2: With `prio_mode` = 2'b11 (external master lowest), the non-refresh priority is channel 0, then channel 1, then external master.
- R3: With `prio_mode` = 2'b01 (channel 0 lowest), the priority is channel 1, then external master, then channel 0.
- R4: With `prio_mode` = 2'b10 (channel 1 lowest), the priority is external master, then channel 0, then channel 1.
- R5: With `prio_mode` = 2'b00 (rotating), a non-refresh winner becomes the lowest priority for later arbitrations, and the cyclic order is kept.
- R6: During and right after reset `grant` is 4'b0000, and the rotating order starts as channel 0, channel 1, external master.
- R7: While the granted requester keeps its request high, `grant` does not change, even if refresh or another higher-ranked request arrives.
- R8: Arbitration takes place only when no grant is being held and `bus_idle` is high. When the owner has dropped its request and `bus_idle` is low, the next `grant` is 4'b0000.
- R9: A refresh grant leaves the rotating order unchanged.
- R10: `grant` has at most one bit set, and only for a requester whose request was high in the cycle before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| prio_mode | input | 2 | 00 rotating, 01 channel 0 lowest, 10 channel 1 lowest, 11 external master lowest |
| req_refresh | input | 1 | Refresh request |
| req_dma0 | input | 1 | DMA channel 0 request |
| req_dma1 | input | 1 | DMA channel 1 request |
| req_ext | input | 1 | External bus master request |
| bus_idle | input | 1 | High when the bus may be handed over |
| grant | output | 4 | One-hot grant, all zero when nobody owns the bus |

## Verification
The assertions assume that requests and `bus_idle` are synchronous to `clk`, that they are stable around the rising edge, and that a requester keeps its request high until it has been granted. They do not assume that `prio_mode` stays fixed while the bus is held. The stimulus changes every input only on the falling edge. It changes the mode only when no grant is held, and it releases all requests between patterns, so every pattern starts from a free bus and the expected order can be derived from a rank computed in the bench.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;

  // Requesters that share the rotatable circle (refresh stands above them).
  localparam int unsigned N_ROT = 3;

  typedef enum logic [1:0] {
    MODE_ROTATE  = 2'b00,
    MODE_LOW_CH0 = 2'b01,
    MODE_LOW_CH1 = 2'b10,
    MODE_LOW_EXT = 2'b11
  } prio_mode_e;

  // First active request scanning circularly from index top.
  function automatic logic [N_ROT-1:0] pick_first(input logic [N_ROT-1:0] req,
                                                  input int unsigned top);
    logic [N_ROT-1:0] res;
    logic found;
    int unsigned idx;
    res   = '0;
    found = 1'b0;
    for (int unsigned k = 0; k < N_ROT; k++) begin
      idx = (top + k) % N_ROT;
      if (!found && req[idx]) begin
        res[idx] = 1'b1;
        found    = 1'b1;
      end
    end
    return res;
  endfunction

  // Head of the circle after a one-hot winner has been served.
  function automatic int unsigned head_after(input logic [N_ROT-1:0] win);
    int unsigned nxt;
    nxt = 0;
    for (int unsigned k = 0; k < N_ROT; k++) begin
      if (win[k]) nxt = (k + 1) % N_ROT;
    end
    return nxt;
  endfunction

endpackage

// File: rtl/bus_arb_order.sv
module bus_arb_order
  import bus_arb_pkg::*;
#(
  parameter int unsigned NR = N_ROT,
  localparam int unsigned TW = (NR > 1) ? $clog2(NR) : 1
) (
  input  logic [1:0]    prio_mode,
  input  logic [TW-1:0] rot_top,
  output logic [TW-1:0] top_idx
);

  // Fixed modes cut the circle just after the requester placed lowest.
  always_comb begin
    case (prio_mode_e'(prio_mode))
      MODE_LOW_CH0: top_idx = TW'(1 % NR);
      MODE_LOW_CH1: top_idx = TW'(2 % NR);
      MODE_LOW_EXT: top_idx = '0;
      default:      top_idx = rot_top;
    endcase
  end

endmodule

// File: rtl/bus_arb_pick.sv
module bus_arb_pick
  import bus_arb_pkg::*;
#(
  parameter int unsigned NR = N_ROT,
  localparam int unsigned TW = (NR > 1) ? $clog2(NR) : 1,
  localparam int unsigned GW = NR + 1
) (
  input  logic          req_refresh,
  input  logic [NR-1:0] req_rot,
  input  logic [TW-1:0] top_idx,
  output logic [GW-1:0] win
);

  logic [NR-1:0] win_rot;

  always_comb begin
    win_rot = '0;
    if (!req_refresh) win_rot = pick_first(req_rot, int'(top_idx));
  end

  assign win = {win_rot, req_refresh};

endmodule

// File: rtl/bus_arb_rotor.sv
module bus_arb_rotor
  import bus_arb_pkg::*;
#(
  parameter int unsigned NR = N_ROT,
  localparam int unsigned TW = (NR > 1) ? $clog2(NR) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd_en,
  input  logic          refresh_win,
  input  logic [NR-1:0] win_rot,
  output logic [TW-1:0] rot_top
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      rot_top <= '0;
    else if (upd_en && (|win_rot))   rot_top <= TW'(head_after(win_rot));
  end

  // R9: a refresh win never moves the head of the circle
  a_r9_refresh_keeps_order: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_win |=> $stable(rot_top));

endmodule

// File: rtl/bus_grant_arbiter.sv
module bus_grant_arbiter
  import bus_arb_pkg::*;
#(
  parameter int unsigned NR = N_ROT,
  localparam int unsigned TW = (NR > 1) ? $clog2(NR) : 1,
  localparam int unsigned GW = NR + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    prio_mode,
  input  logic          req_refresh,
  input  logic          req_dma0,
  input  logic          req_dma1,
  input  logic          req_ext,
  input  logic          bus_idle,
  output logic [GW-1:0] grant
);

  logic [GW-1:0] req_vec;
  logic [GW-1:0] win;
  logic [GW-1:0] grant_nxt;
  logic [TW-1:0] rot_top;
  logic [TW-1:0] top_idx;
  logic          hold;
  logic          arb_now;
  logic          rot_mode;
  logic          upd_en;
  logic          refresh_win;

  assign req_vec     = GW'({req_ext, req_dma1, req_dma0, req_refresh});
  assign hold        = |(grant & req_vec);
  assign arb_now     = !hold && bus_idle;
  assign rot_mode    = (prio_mode_e'(prio_mode) == MODE_ROTATE);
  assign refresh_win = arb_now && win[0];
  assign upd_en      = arb_now && rot_mode && !win[0];

  bus_arb_rotor #(.NR(NR)) u_rotor (
    .clk         (clk),
    .rst_n       (rst_n),
    .upd_en      (upd_en),
    .refresh_win (refresh_win),
    .win_rot     (win[GW-1:1]),
    .rot_top     (rot_top)
  );

  bus_arb_order #(.NR(NR)) u_order (
    .prio_mode (prio_mode),
    .rot_top   (rot_top),
    .top_idx   (top_idx)
  );

  bus_arb_pick #(.NR(NR)) u_pick (
    .req_refresh (req_refresh),
    .req_rot     (req_vec[GW-1:1]),
    .top_idx     (top_idx),
    .win         (win)
  );

  always_comb begin
    if (hold)         grant_nxt = grant;
    else if (arb_now) grant_nxt = win;
    else              grant_nxt = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) grant <= '0;
    else        grant <= grant_nxt;
  end

  // R10: at most one owner
  a_r10_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R10: an owner had asked in the previous cycle
  a_r10_only_requesters: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((grant & $past(req_vec)) == grant));

  // R1: refresh beats everybody at an arbitration
  a_r1_refresh_first: assert property (@(posedge clk) disable iff (!rst_n)
    arb_now && req_refresh |=> grant == GW'(1));

  // R7: ownership sticks while the owner keeps asking
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(grant));

  // R8: no handover while the bus is busy
  a_r8_busy_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
    !hold && !bus_idle |=> grant == '0);

  // R5: a rotating winner is not at the head afterwards
  a_r5_winner_drops: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en && win[1] |=> rot_top != '0);

endmodule

// File: tb/bus_grant_arbiter_bench.sv
`timescale 1ns/1ps
module bus_grant_arbiter_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] prio_mode = 2'b00;
  logic [3:0] rq = 4'b0000;   // {ext, dma1, dma0, refresh}
  logic       bus_idle = 1'b1;
  logic [3:0] grant;

  int n_cmp = 0;
  int n_bad = 0;
  int exp_top = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bus_grant_arbiter u_bus_grant_arbiter (
    .clk         (clk),
    .rst_n       (rst_n),
    .prio_mode   (prio_mode),
    .req_refresh (rq[0]),
    .req_dma0    (rq[1]),
    .req_dma1    (rq[2]),
    .req_ext     (rq[3]),
    .bus_idle    (bus_idle),
    .grant       (grant)
  );

  // Rank of circle member i when the head is top: 0 best.
  function automatic logic [3:0] model(input logic [3:0] r, input int top);
    int best, bi, rank;
    if (r[0]) return 4'b0001;
    best = 3; bi = -1;
    for (int i = 0; i < 3; i++) begin
      rank = (i + 3 - top) % 3;
      if (r[i+1] && rank < best) begin best = rank; bi = i; end
    end
    if (bi < 0) return 4'b0000;
    return 4'b0010 << bi;
  endfunction

  task automatic check(input logic [3:0] exp, input string tag);
    n_cmp++;
    if (grant !== exp) begin
      n_bad++;
      $display("FAIL %s: grant=%b expected=%b", tag, grant, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // Present one request pattern on a free, idle bus, then release it.
  task automatic apply(input logic [3:0] pat, input string tag);
    logic [3:0] e;
    e = model(pat, (prio_mode == 2'b00) ? exp_top : (prio_mode == 2'b01) ? 1 :
                   (prio_mode == 2'b10) ? 2 : 0);
    rq = pat; bus_idle = 1'b1;
    tick();
    check(e, tag);
    if (prio_mode == 2'b00)
      for (int i = 0; i < 3; i++) if (e[i+1]) exp_top = (i + 1) % 3;
    rq = 4'b0000;
    tick();
    check(4'b0000, tag);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: grant=%b expected=done", grant);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    tick();
    check(4'b0000, "R6 in reset");
    rst_n = 1'b1;
    tick();
    check(4'b0000, "R6 after reset");

    // R6: rotation starts with dma0 at the head
    apply(4'b1110, "R6 initial order");
    // R5: after dma0 wins, dma1 leads, then ext, then dma0
    apply(4'b1010, "R5 dma0 now last");
    // R9: refresh grant must not move the head
    apply(4'b0001, "R9 refresh grant");
    apply(4'b1111, "R1 refresh over all");
    apply(4'b1110, "R9 order after refresh");

    // R5: rotating sweep over all patterns
    for (int rep = 0; rep < 3; rep++)
      for (int p = 1; p < 16; p++) apply(4'(p), "R5 rotating sweep");

    prio_mode = 2'b01;
    for (int p = 0; p < 16; p++) apply(4'(p), "R3 channel 0 lowest");
    prio_mode = 2'b10;
    for (int p = 0; p < 16; p++) apply(4'(p), "R4 channel 1 lowest");
    prio_mode = 2'b11;
    for (int p = 0; p < 16; p++) apply(4'(p), "R2 external lowest");

    // R7: hold under a later higher request
    rq = 4'b1000; tick();
    check(4'b1000, "R7 ext granted");
    rq = 4'b1111; tick();
    check(4'b1000, "R7 hold vs refresh");
    tick();
    check(4'b1000, "R7 hold second cycle");
    rq = 4'b0111; tick();
    check(4'b0001, "R1 refresh after release");
    rq = 4'b0000; tick();
    check(4'b0000, "R7 released");

    // R8: busy bus blocks handover
    bus_idle = 1'b0; rq = 4'b0100; tick();
    check(4'b0000, "R8 busy no grant");
    tick();
    check(4'b0000, "R8 still busy");
    bus_idle = 1'b1; tick();
    check(4'b0100, "R8 idle grants dma1");
    bus_idle = 1'b0; rq = 4'b0010; tick();
    check(4'b0000, "R8 owner dropped while busy");
    bus_idle = 1'b1; tick();
    check(4'b0010, "R10 next owner dma0");
    rq = 4'b0000; tick();
    check(4'b0000, "R10 free");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule